// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

One timer channel that counts down from a period value and drives a pulse-width-modulated output. Software writes the period and the compare threshold into staging registers. Those values reach the live counter and the live threshold in only two cases: while a manual-update control bit is held high, or when the counter reloads itself after reaching zero. A new setting therefore never tears a cycle that is already running.

The output is active while the live count is above the live threshold. One cycle of N+1 ticks, for a period value N, is active for N−C ticks, where C is the compare value. An external prescaler supplies a one-cycle tick enable that paces the counter. A one-cycle terminal-count pulse marks each arrival at zero and can serve as an interrupt request. A parameter builds a timer-only variant, which has no compare storage and no output drive.

The control sequencer has three states:
- `ST_STOP`: halted, count held.
- `ST_RUN`: counting on ticks.
- `ST_DONE`: a one-shot run has ended at zero.

Its transitions are:
- STOP→RUN when the start bit is set.
- RUN→STOP and DONE→STOP when the start bit is cleared.
- RUN→DONE on a tick at count zero while auto-reload is clear.
- DONE→RUN on a manual update while start is set.

Top module: `pwm_dbuf_chan`

## Requirements
- R1: After reset the working count, all readable registers, `pwm_out` and `tc_pulse` are 0.
- R2: Register map: address 0 is the period staging value, address 1 is the compare staging value, address 2 is control and address 3 is the read-only working count. Writing addresses 0 and 1 does not change the working count.
- R3: While control bit 1 (update) is high, the working count and working compare are loaded from staging on every clock. No decrement happens and no terminal pulse is produced, even when start and tick are present.
- R4: Once the update bit is clear, later staging writes leave the working count unchanged until the next reload at zero.
- R5: While running (control bit 0, start) the count decrements by one per cycle with `tick_en` high. It holds while `tick_en` is low.
- R6: With control bit 3 (auto-reload) set, a tick at count 0 reloads both working values from staging. The terminal pulses are then period+1 ticks apart.
- R7: The output is active while running and count > compare. With a tick every cycle this gives period−compare active cycles per period+1 cycles.
- R8: `tc_pulse` is high for exactly one cycle each time a tick moves the count from 1 to 0.
- R9: Control bit 2 (invert) flips `pwm_out`. When stopped, `pwm_out` sits at the inactive level, which is 1 when inverted and 0 otherwise.
- R10: Clearing start holds the count. Setting start again resumes from the held value.
- R11: With auto-reload clear, the count stops at 0, stays there, and yields one terminal pulse.
- R12: With `HAS_OUT`=0, `pwm_out` stays 0 whatever the invert bit is, and compare reads 0. Counting and `tc_pulse` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Prescaler tick, one count step per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Write data |
| reg_rdata | output | CNT_W | Read data for `reg_addr` (combinational) |
| pwm_out | output | 1 | PWM output, registered |
| tc_pulse | output | 1 | One-cycle pulse on reaching zero |

## Verification
A manual update and a count step, including the step that would reach zero, can both be requested in the same cycle. To provoke this, the bench holds the update bit high together with start, auto-reload and a tick on every cycle while the channel is running. The update is judged to win if the read-back count stays at the staged period for every held cycle and `tc_pulse` never rises. A second collision combines the update with a start-bit change: the bench checks that the staged period is loaded and that the subsequent one-shot run produces exactly one terminal pulse.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } run_state_e;

    // control field; bit order is the software-visible encoding
    typedef struct packed {
        logic auto_rl;   // bit 3
        logic invert;    // bit 2
        logic update;    // bit 1
        logic start;     // bit 0
    } ctrl_t;

    localparam int unsigned CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] ADDR_PERIOD = 2'd0;
    localparam logic [1:0] ADDR_CMP    = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
    localparam logic [1:0] ADDR_COUNT  = 2'd3;

endpackage

// File: rtl/pwm_dbuf_regs.sv
module pwm_dbuf_regs
    import pwm_dbuf_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter bit          HAS_CMP = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [1:0]       addr_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] period_o,
    output logic [CNT_W-1:0] cmp_o,
    output ctrl_t            ctrl_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            period_o <= '0;
            ctrl_o   <= '0;
        end else if (wr_i) begin
            if (addr_i == ADDR_PERIOD) period_o <= wdata_i;
            if (addr_i == ADDR_CTRL)   ctrl_o   <= ctrl_t'(wdata_i[CTRL_W-1:0]);
        end
    end

    generate
        if (HAS_CMP) begin : g_cmp
            logic [CNT_W-1:0] cmp_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                           cmp_q <= '0;
                else if (wr_i && addr_i == ADDR_CMP)  cmp_q <= wdata_i;
            end
            assign cmp_o = cmp_q;
        end else begin : g_no_cmp
            assign cmp_o = '0;
        end
    endgenerate

endmodule

// File: rtl/pwm_dbuf_counter.sv
module pwm_dbuf_counter
    import pwm_dbuf_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             update_i,
    input  logic             auto_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cmp_work_o,
    output logic             running_o,
    output logic             tc_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    run_state_e       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, cmpw_q, cmpw_d;
    logic             tc_q, tc_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= ST_STOP;
            cnt_q  <= '0;
            cmpw_q <= '0;
            tc_q   <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            cmpw_q <= cmpw_d;
            tc_q   <= tc_d;
        end
    end

    always_comb begin
        st_d   = st_q;
        cnt_d  = cnt_q;
        cmpw_d = cmpw_q;
        tc_d   = 1'b0;
        if (update_i) begin
            cnt_d  = period_i;
            cmpw_d = cmp_i;
        end
        unique case (st_q)
            ST_STOP: begin
                if (start_i) st_d = ST_RUN;
            end
            ST_RUN: begin
                if (!start_i) begin
                    st_d = ST_STOP;
                end else if (!update_i && tick_i) begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - ONE;
                        tc_d  = (cnt_q == ONE);
                    end else if (auto_i) begin
                        cnt_d  = period_i;
                        cmpw_d = cmp_i;
                    end else begin
                        st_d = ST_DONE;
                    end
                end
            end
            ST_DONE: begin
                if (!start_i)     st_d = ST_STOP;
                else if (update_i) st_d = ST_RUN;
            end
            default: st_d = ST_STOP;
        endcase
    end

    assign cnt_o      = cnt_q;
    assign cmp_work_o = cmpw_q;
    assign running_o  = (st_q == ST_RUN);
    assign tc_o       = tc_q;

    // R3: a held update strobe loads the staged period on the next edge
    a_r3_update_loads: assert property (@(posedge clk) disable iff (!rst_n)
        update_i |=> (cnt_q == $past(period_i)));

    // R5: one step down per tick while running
    a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && start_i && !update_i && tick_i && cnt_q != '0)
        |=> (cnt_q == $past(cnt_q) - ONE));

    // R10: outside RUN, without update, the count is frozen
    a_r10_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN && !update_i) |=> $stable(cnt_q));

    // R8: terminal pulse never lasts two cycles
    a_r8_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
        tc_q |=> !tc_q);

    // R11: the finished one-shot state sits at zero
    a_r11_done_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE) |-> (cnt_q == '0));

endmodule

// File: rtl/pwm_dbuf_outstage.sv
module pwm_dbuf_outstage #(
    parameter int unsigned CNT_W   = 16,
    parameter bit          HAS_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             running_i,
    input  logic             invert_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic             pwm_o
);

    logic active, pwm_d, pwm_q;

    assign active = running_i && (cnt_i > cmp_i);
    assign pwm_d  = HAS_OUT ? (active ^ invert_i) : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pwm_q <= 1'b0;
        else        pwm_q <= pwm_d;
    end

    assign pwm_o = pwm_q;

    // R9/R12: a stopped channel shows the inactive level one cycle later
    a_r9_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        !running_i |=> (pwm_q == (HAS_OUT && $past(invert_i))));

endmodule

// File: rtl/pwm_dbuf_chan.sv
module pwm_dbuf_chan
    import pwm_dbuf_pkg::*;
#(
    parameter int unsigned CNT_W   = 16,
    parameter bit          HAS_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             pwm_out,
    output logic             tc_pulse
);

    ctrl_t            ctrl;
    logic [CNT_W-1:0] period_buf, cmp_buf, cnt_work, cmp_work;
    logic             running;

    pwm_dbuf_regs #(.CNT_W(CNT_W), .HAS_CMP(HAS_OUT)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_i(reg_wr), .addr_i(reg_addr),
        .wdata_i(reg_wdata), .period_o(period_buf), .cmp_o(cmp_buf),
        .ctrl_o(ctrl)
    );

    pwm_dbuf_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .start_i(ctrl.start),
        .update_i(ctrl.update), .auto_i(ctrl.auto_rl), .tick_i(tick_en),
        .period_i(period_buf), .cmp_i(cmp_buf), .cnt_o(cnt_work),
        .cmp_work_o(cmp_work), .running_o(running), .tc_o(tc_pulse)
    );

    pwm_dbuf_outstage #(.CNT_W(CNT_W), .HAS_OUT(HAS_OUT)) u_out (
        .clk(clk), .rst_n(rst_n), .running_i(running),
        .invert_i(ctrl.invert), .cnt_i(cnt_work), .cmp_i(cmp_work),
        .pwm_o(pwm_out)
    );

    always_comb begin
        unique case (reg_addr)
            ADDR_PERIOD: reg_rdata = period_buf;
            ADDR_CMP:    reg_rdata = cmp_buf;
            ADDR_CTRL:   reg_rdata = CNT_W'(ctrl);
            default:     reg_rdata = cnt_work;
        endcase
    end

endmodule

// File: tb/pwm_dbuf_chan_bench.sv
module pwm_dbuf_chan_bench;

    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         reg_wr = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] rdata_a, rdata_b;
    logic         pwm_a, pwm_b, tc_a, tc_b;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwm_dbuf_chan #(.CNT_W(W), .HAS_OUT(1'b1)) u_pwm_dbuf_chan (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_a),
        .pwm_out(pwm_a), .tc_pulse(tc_a));

    pwm_dbuf_chan #(.CNT_W(W), .HAS_OUT(1'b0)) u_pwm_dbuf_chan_tmr (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(rdata_b),
        .pwm_out(pwm_b), .tc_pulse(tc_b));

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input int d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = W'(d);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int va, output int vb);
        reg_addr = a;
        #1;
        va = int'(rdata_a);
        vb = int'(rdata_b);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // count PWM-high and tc cycles over a window, and the tc spacing
    task automatic window(input int n, output int hi_a, output int hi_b,
                          output int tca, output int tcb, output int gap);
        int last;
        hi_a = 0; hi_b = 0; tca = 0; tcb = 0; gap = -1; last = -1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            hi_a += int'(pwm_a); hi_b += int'(pwm_b);
            tcb  += int'(tc_b);
            if (tc_a) begin
                tca++;
                if (last >= 0) gap = i - last;
                last = i;
            end
        end
    endtask

    task automatic t_reset;
        int va, vb;
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), va, vb);
            check("R1 reg", va, 0);
            check("R1 reg tmr", vb, 0);
        end
        check("R1 pwm", int'(pwm_a), 0);
        check("R1 tc", int'(tc_a), 0);
    endtask

    task automatic t_buffers;
        int va, vb;
        wr(2'd0, 9);
        wr(2'd1, 3);
        rd(2'd3, va, vb); check("R2 count untouched", va, 0);
        rd(2'd0, va, vb); check("R2 period", va, 9);
        rd(2'd1, va, vb); check("R2 compare", va, 3);
        check("R12 compare absent", vb, 0);
    endtask

    task automatic t_update_load;
        int va, vb;
        tick_en = 1'b1;
        wr(2'd2, 'h2);
        wr(2'd2, 'h0);
        rd(2'd3, va, vb); check("R3 loaded", va, 9);
        check("R3 loaded tmr", vb, 9);
        idle(5);
        rd(2'd3, va, vb); check("R10 stopped hold", va, 9);
    endtask

    task automatic t_pwm_run;
        int ha, hb, ta, tb, g;
        wr(2'd2, 'h9);
        idle(3);
        window(20, ha, hb, ta, tb, g);
        check("R7 active cycles", ha, 12);
        check("R8 tc count", ta, 2);
        check("R6 tc spacing", g, 10);
        check("R12 tmr no pwm", hb, 0);
        check("R12 tmr tc", tb, 2);
    endtask

    task automatic t_invert;
        int ha, hb, ta, tb, g;
        wr(2'd2, 'hD);
        idle(3);
        window(20, ha, hb, ta, tb, g);
        check("R9 inverted high", ha, 8);
        check("R12 invert ignored", hb, 0);
    endtask

    task automatic t_halt_tick;
        int v1, v2, vb, e;
        wr(2'd2, 'h4);
        idle(2);
        rd(2'd3, v1, vb);
        idle(5);
        rd(2'd3, v2, vb);
        check("R10 held", v2, v1);
        check("R9 idle inverted level", int'(pwm_a), 1);
        wr(2'd2, 'h9);
        tick_en = 1'b0;
        idle(2);
        rd(2'd3, v1, vb);
        idle(4);
        rd(2'd3, v2, vb);
        check("R5 no tick hold", v2, v1);
        tick_en = 1'b1;
        @(negedge clk);
        tick_en = 1'b0;
        rd(2'd3, v2, vb);
        e = (v1 == 0) ? 9 : v1 - 1;
        check("R5 single step", v2, e);
        tick_en = 1'b1;
    endtask

    task automatic t_update_priority;
        int va, vb, tcs;
        wr(2'd2, 'hB);
        idle(1);
        tcs = 0;
        for (int i = 0; i < 6; i++) begin
            rd(2'd3, va, vb);
            check("R3 held update count", va, 9);
            tcs += int'(tc_a);
            @(negedge clk);
        end
        check("R3 no tc under update", tcs, 0);
        wr(2'd2, 'h9);
    endtask

    task automatic t_oneshot;
        int ha, hb, ta, tb, g, va, vb;
        wr(2'd0, 4);
        wr(2'd2, 'h2);
        wr(2'd2, 'h1);
        window(20, ha, hb, ta, tb, g);
        check("R11 one tc", ta, 1);
        check("R7 one-shot active", ha, 1);
        rd(2'd3, va, vb); check("R11 stays zero", va, 0);
        wr(2'd0, 7);
        idle(3);
        rd(2'd3, va, vb); check("R4 no reload", va, 0);
        check("R4 no tc", int'(tc_a), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        idle(2);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_buffers();
        t_update_load();
        t_pwm_run();
        t_invert();
        t_halt_tick();
        t_update_priority();
        t_oneshot();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule